// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shift and rotate datapath of an execution unit. It takes one register operand of 8 or 16 bits, a 3-bit operation code, a shift count and the incoming carry flag. It returns the shifted or rotated value together with the new carry flag. There are eight operations: four shifts (logical and arithmetic, in both directions) and four rotates (plain and through-carry, in both directions). The through-carry rotates treat the carry flag as one extra bit above the operand, so the rotation spans WIDTH+1 bits.

The datapath is purely combinational. When `REGISTERED` is set, a single output register is added and clocked by `clk`. The count runs from zero up to the operand width. Larger count values that fit the count port are also defined, so any value a caller drives gives a known result. The block does not produce overflow, sign, zero or parity flags.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 0 is a logical left shift. Zeros enter at bit 0, and the carry out is the last bit that leaves the top. The codes are 0 SHL, 1 SHR, 2 SAL, 3 SAR, 4 ROL, 5 ROR, 6 RCL, 7 RCR.
- R2: Operation code 2 (arithmetic left) gives exactly the same result and carry as code 0.
- R3: Operation code 1 is a logical right shift. Zeros enter at the top, and the carry out is the last bit that leaves bit 0.
- R4: Operation code 3 is an arithmetic right shift. Copies of the original top bit enter at the top, and the carry out is the last bit that leaves bit 0.
- R5: Operation code 4 rotates left. Each bit that leaves the top re-enters at bit 0, and the carry out is the last bit moved across.
- R6: Operation code 5 rotates right. Each bit that leaves bit 0 re-enters at the top, and the carry out is the last bit moved across.
- R7: Operation code 6 rotates left through carry. At each step the top bit goes to the carry and the old carry goes to bit 0.
- R8: Operation code 7 rotates right through carry. At each step bit 0 goes to the carry and the old carry goes to the top.
- R9: A count of zero returns the operand unchanged and passes the carry in to the carry out, for every operation.
- R10: For counts above WIDTH, logical shifts return zero with a carry of zero. Arithmetic right returns all sign bits with the carry equal to the sign. Plain rotates use the count modulo WIDTH, and through-carry rotates use the count modulo WIDTH+1. A nonzero count that is a multiple of the modulus leaves the value unchanged, and the carry out is bit 0 (ROL), the top bit (ROR) or the carry in (through-carry).
- R11: With `REGISTERED` set, the outputs appear one clock after the inputs, and the asynchronous active-low reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op | input | 3 | Operation code |
| count | input | $clog2(WIDTH+1) | Number of bit positions to move |
| operand | input | WIDTH | Value to shift or rotate |
| carry_in | input | 1 | Incoming carry flag |
| result | output | WIDTH | Shifted or rotated value |
| carry_out | output | 1 | Outgoing carry flag |

## Verification
The assertions assume that the inputs are stable at each sampling edge. In the registered variant they assume that the outputs belong to the inputs seen at the previous edge, so the checker keeps its own delayed copy of the inputs. They also assume that every count value the port can carry is legal. The stimulus changes the inputs only on falling edges. It sweeps every operation, every count including the values above WIDTH, every operand and both carry values, so it never leaves the domain the properties are written for.

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit #(
  parameter int WIDTH = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [CW-1:0]    count,
  input  logic [WIDTH-1:0] operand,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int KW = CW + 1;
  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAL = 3'd2, OP_SAR = 3'd3,
                         OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RCL = 3'd6, OP_RCR = 3'd7;

  logic [CW-1:0]    k_rot, k_rc;
  logic [WIDTH:0]   shr_x, sar_x, shl_x, rc_v, rcl_v, rcr_v;
  logic [WIDTH-1:0] rol_v, ror_v, res_d;
  logic             cy_d;

  assign k_rot = CW'(KW'(count) % KW'(WIDTH));
  assign k_rc  = CW'(KW'(count) % KW'(WIDTH + 1));

  assign shr_x = {operand, 1'b0} >> count;
  assign sar_x = $signed({operand, 1'b0}) >>> count;
  assign shl_x = {1'b0, operand} << count;

  assign rol_v = (operand << k_rot) | (operand >> (WIDTH - int'(k_rot)));
  assign ror_v = (operand >> k_rot) | (operand << (WIDTH - int'(k_rot)));

  assign rc_v  = {carry_in, operand};
  assign rcl_v = (rc_v << k_rc) | (rc_v >> (WIDTH + 1 - int'(k_rc)));
  assign rcr_v = (rc_v >> k_rc) | (rc_v << (WIDTH + 1 - int'(k_rc)));

  always_comb begin
    res_d = operand;
    cy_d  = carry_in;
    if (count != '0) begin
      case (op)
        OP_SHL, OP_SAL: begin res_d = shl_x[WIDTH-1:0]; cy_d = shl_x[WIDTH]; end
        OP_SHR:         begin res_d = shr_x[WIDTH:1];   cy_d = shr_x[0];     end
        OP_SAR:         begin res_d = sar_x[WIDTH:1];   cy_d = sar_x[0];     end
        OP_ROL:         begin res_d = rol_v;            cy_d = rol_v[0];     end
        OP_ROR:         begin res_d = ror_v;            cy_d = ror_v[WIDTH-1]; end
        OP_RCL:         begin res_d = rcl_v[WIDTH-1:0]; cy_d = rcl_v[WIDTH]; end
        default:        begin res_d = rcr_v[WIDTH-1:0]; cy_d = rcr_v[WIDTH]; end
      endcase
    end
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= 1'b0;
        end else begin
          result    <= res_d;
          carry_out <= cy_d;
        end
      end
    end else begin : g_comb
      assign result    = res_d;
      assign carry_out = cy_d;
    end
  endgenerate
endmodule

// File: rtl/shift_rotate_unit_chk.sv
`timescale 1ns/1ps
module shift_rotate_unit_chk #(
  parameter int WIDTH = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic [CW-1:0]    count,
  input logic [WIDTH-1:0] operand,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [2:0]       op_v;
  logic [CW-1:0]    cnt_v;
  logic [WIDTH-1:0] opd_v;
  logic             cin_v;

  generate
    if (REGISTERED) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          op_v <= '0; cnt_v <= '0; opd_v <= '0; cin_v <= 1'b0;
        end else begin
          op_v <= op; cnt_v <= count; opd_v <= operand; cin_v <= carry_in;
        end
      end
    end else begin : g_live
      assign op_v  = op;
      assign cnt_v = count;
      assign opd_v = operand;
      assign cin_v = carry_in;
    end
  endgenerate

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_v == '0) |-> (result == opd_v && carry_out == cin_v));

  // R1
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_v == 3'd0 || op_v == 3'd2) && cnt_v != '0) |-> (result[0] == 1'b0));

  // R3
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 3'd1 && cnt_v != '0) |-> (result[WIDTH-1] == 1'b0));

  // R4
  sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 3'd3) |-> (result[WIDTH-1] == opd_v[WIDTH-1]));

  // R5
  rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 3'd4 || op_v == 3'd5) |-> ($countones(result) == $countones(opd_v)));

  // R7
  rc_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 3'd6 || op_v == 3'd7) |->
      ($countones({carry_out, result}) == $countones({cin_v, opd_v})));

  // R10
  over_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_v == 3'd0 || op_v == 3'd1 || op_v == 3'd2) && int'(cnt_v) > WIDTH) |->
      (result == '0 && carry_out == 1'b0));
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]    op = '0;
  logic [CW-1:0] cnt = '0;
  logic [W-1:0]  opd = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  res_c, res_r;
  logic          cout_c, cout_r;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W), .REGISTERED(1'b0)) i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .count(cnt), .operand(opd), .carry_in(cin),
    .result(res_c), .carry_out(cout_c));

  shift_rotate_unit #(.WIDTH(W), .REGISTERED(1'b1)) i_shift_rotate_unit_reg (
    .clk(clk), .rst_n(rst_n), .op(op), .count(cnt), .operand(opd), .carry_in(cin),
    .result(res_r), .carry_out(cout_r));

  function automatic logic [W:0] model(input logic [2:0] o, input int n,
                                       input logic [W-1:0] xi, input logic ci);
    logic [W-1:0] x = xi;
    logic c = ci;
    logic t;
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0, 3'd2: begin c = x[W-1]; x = {x[W-2:0], 1'b0}; end
        3'd1:       begin c = x[0];   x = {1'b0, x[W-1:1]}; end
        3'd3:       begin c = x[0];   x = {x[W-1], x[W-1:1]}; end
        3'd4:       begin c = x[W-1]; x = {x[W-2:0], x[W-1]}; end
        3'd5:       begin c = x[0];   x = {x[0], x[W-1:1]}; end
        3'd6:       begin t = x[W-1]; x = {x[W-2:0], c}; c = t; end
        default:    begin t = x[0];   x = {c, x[W-1:1]}; c = t; end
      endcase
    end
    return {c, x};
  endfunction

  function automatic string tag(input logic [2:0] o, input int n);
    if (n == 0) return "R9";
    if (n > W) return "R10";
    case (o)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R2";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d cnt=%0d opd=%h cin=%b actual=%h expected=%h",
               req, op, cnt, opd, cin, act, exp);
    end
  endtask

  initial begin
    logic [W:0] exp_v;
    logic [W:0] prev;
    bit have_prev = 1'b0;
    prev = '0;
    repeat (3) @(negedge clk);
    // R11: reset clears the registered outputs
    check("R11", {cout_r, res_r}, '0);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < (1 << CW); n++)
        for (int v = 0; v < (1 << W); v++)
          for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            // R11: registered copy lags by one clock
            if (have_prev) check("R11", {cout_r, res_r}, prev);
            op = 3'(o); cnt = CW'(n); opd = W'(v); cin = c[0];
            exp_v = model(op, n, opd, cin);
            #1;
            check(tag(op, n), {cout_c, res_c}, exp_v);
            prev = exp_v;
            have_prev = 1'b1;
          end
    @(negedge clk);
    check("R11", {cout_r, res_r}, prev);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule